// File: doc/BRIEF.md
# Self-Framing Serial Display Latch Driver

This block takes display data over two wires, a serial clock and a serial data line, and drives a bank of parallel display outputs with no multiplexing. No strobe pin marks the end of a transfer. Each transfer opens with a single 1 bit, and 35 payload bits follow it. The block watches that leading 1 move through its receive window. When the 1 reaches the far end, the block has the whole payload and copies it into an output latch. It then empties the window, so the next transfer has to open with a fresh leading 1.

Both serial wires are brought into the system clock domain through flop synchronisers. A bit is taken on each detected rising edge of the serial clock. Each half of the serial clock, high and low, must last at least `SYNC_STAGES + 1` system cycles. The data line must be steady around each rising edge. The serial link carries no back-pressure and has no handshake. A parameter selects a gated variant. In that variant the last output is removed, leaving 34. An enable input then decides whether serial clock edges are accepted. Reset must be held for at least `SYNC_STAGES + 1` cycles so that the synchronisers settle before the first edge is taken.

Top module: `serdisp_latch_top`

## Requirements
- R1: A transfer is one 1 bit followed by 35 payload bits. The output latch is loaded on the 36th accepted rising edge of the serial clock, and no load or strobe pin exists.
- R2: The first payload bit after the leading 1 drives `seg_o[0]`, and payload bit k (counted from 1) drives `seg_o[k-1]`. In the ungated variant the 35th payload bit drives `seg_o[34]`.
- R3: A load happens only on the edge that brings in the 35th payload bit after a leading 1.
- R4: `seg_o` holds its value between loads, including while a transfer is only partly received.
- R5: Loading a payload equal to the one already latched leaves every output unchanged.
- R6: After a load the receive window is empty. A new transfer that starts on the very next serial edge is received correctly.
- R7: While no transfer is open, 0 bits on the data line are discarded and do not open a transfer.
- R8: With `GATED=1`, `seg_o` has 34 bits and the 35th payload bit is discarded. Rising edges of the serial clock are ignored while `ser_en_i` is 0, and the partial transfer is kept intact.
- R9: With `GATED=0`, `ser_en_i` has no effect.
- R10: A synchronous active-high `rst_i` clears the receive window, the payload count and all outputs to 0. It overrides a load that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock; a bit is taken on each rising edge |
| ser_dat_i | input | 1 | Serial data line |
| ser_en_i | input | 1 | Receive enable, active high; used only when GATED=1 |
| seg_o | output | NOUT (35, or 34 when GATED=1) | Latched parallel display outputs |

## Verification
The self-generated load and the synchronous reset can land in the same system cycle. In that cycle the load tries to write the latch and the reset tries to clear it. The bench provokes this by raising the 36th serial clock edge and then driving reset so that it is sampled on exactly the cycle in which that edge is acted on. The result is judged at the outputs: they must go to zero rather than show the payload, and a full transfer sent right afterwards must land intact, which shows the receive window was emptied.

// File: rtl/serdisp_pkg.sv
package serdisp_pkg;

  // payload bits carried after the leading marker bit
  localparam int unsigned FRAME_PAYLOAD = 35;

  // receive phase: waiting for the marker, or collecting payload
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_BODY = 1'b1
  } rx_phase_e;

  // the gated variant gives up the last output to the enable input
  function automatic int unsigned out_count(input int unsigned payload, input bit gated);
    return gated ? payload - 1 : payload;
  endfunction

endpackage

// File: rtl/serdisp_sync.sv
module serdisp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  // plain flop chain, no reset: it settles while reset is held
  always_ff @(posedge clk_i) begin
    chain_q[0] <= d_i;
    for (int s = 1; s < int'(STAGES); s++) begin
      chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/serdisp_edge.sv
module serdisp_edge #(
  parameter bit GATED = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sck_i,
  input  logic en_i,
  output logic step_o
);

  logic prev_q;
  logic rise;

  always_ff @(posedge clk_i) begin
    prev_q <= sck_i;
  end

  assign rise = sck_i & ~prev_q;

  if (GATED) begin : g_gated
    assign step_o = rise & en_i;
  end else begin : g_free
    logic unused_en;
    assign unused_en = en_i;
    assign step_o    = rise;
  end

  // one serial edge yields exactly one step cycle
  assert_single_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    step_o |=> !step_o);

endmodule

// File: rtl/serdisp_shift.sv
module serdisp_shift
  import serdisp_pkg::*;
#(
  parameter int unsigned PAYLOAD = FRAME_PAYLOAD
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               step_i,
  input  logic               dat_i,
  output logic               load_o,
  output logic [PAYLOAD-1:0] frame_o
);

  localparam int unsigned     CNT_W    = (PAYLOAD > 1) ? $clog2(PAYLOAD) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD - 1);

  logic [PAYLOAD-1:0] win_q;
  logic [PAYLOAD:0]   win_nxt;
  logic [CNT_W-1:0]   cnt_q;
  rx_phase_e          phase_q;

  // the marker's arrival at the top slot is seen combinationally, so it needs no flop
  assign win_nxt = {win_q, dat_i};
  assign load_o  = step_i & win_nxt[PAYLOAD];
  assign frame_o = win_nxt[PAYLOAD-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q   <= '0;
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
    end else if (step_i) begin
      if (win_nxt[PAYLOAD]) begin
        win_q   <= '0;
        cnt_q   <= '0;
        phase_q <= PH_IDLE;
      end else begin
        win_q <= win_nxt[PAYLOAD-1:0];
        if (phase_q == PH_IDLE) begin
          if (dat_i) phase_q <= PH_BODY;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // the marker's travel and the payload count must agree on where a transfer ends
  assert_load_on_last_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |-> (phase_q == PH_BODY && cnt_q == LAST_IDX));

  assert_last_loads_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && phase_q == PH_BODY && cnt_q == LAST_IDX) |-> load_o);

  assert_idle_empty_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_IDLE) |-> (win_q == '0));

  assert_clear_after_load_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    load_o |=> (win_q == '0 && phase_q == PH_IDLE));

  assert_hold_no_step_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> ($stable(win_q) && $stable(cnt_q)));

endmodule

// File: rtl/serdisp_latch.sv
module serdisp_latch #(
  parameter int unsigned PAYLOAD = 35,
  parameter int unsigned NOUT    = 35
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               ld_i,
  input  logic [PAYLOAD-1:0] frame_i,
  output logic [NOUT-1:0]    seg_o
);

  logic [NOUT-1:0] mapped;
  logic [NOUT-1:0] lat_q;

  // earliest payload bit sits highest in the window and maps to output 0
  for (genvar i = 0; i < int'(NOUT); i++) begin : g_map
    assign mapped[i] = frame_i[PAYLOAD-1-i];
  end

  if (NOUT < PAYLOAD) begin : g_drop
    logic unused_tail;
    assign unused_tail = ^frame_i[PAYLOAD-1-NOUT:0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lat_q <= '0;
    end else if (ld_i) begin
      lat_q <= mapped;
    end
  end

  assign seg_o = lat_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_i |=> $stable(lat_q));

  assert_same_quiet_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_i && mapped == lat_q) |=> $stable(lat_q));

  assert_reset_clear_R10: assert property (@(posedge clk_i)
    rst_i |=> (lat_q == '0));

endmodule

// File: rtl/serdisp_latch_top.sv
module serdisp_latch_top
  import serdisp_pkg::*;
#(
  parameter int unsigned  PAYLOAD     = FRAME_PAYLOAD,
  parameter bit           GATED       = 1'b0,
  parameter int unsigned  SYNC_STAGES = 2,
  localparam int unsigned NOUT        = out_count(PAYLOAD, GATED)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            ser_clk_i,
  input  logic            ser_dat_i,
  input  logic            ser_en_i,
  output logic [NOUT-1:0] seg_o
);

  localparam int unsigned SYNC_W = 3;

  logic [SYNC_W-1:0]  raw_in;
  logic [SYNC_W-1:0]  synced;
  logic               step;
  logic               load;
  logic [PAYLOAD-1:0] frame;

  assign raw_in = {ser_en_i, ser_dat_i, ser_clk_i};

  serdisp_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .d_i   (raw_in),
    .q_o   (synced)
  );

  serdisp_edge #(
    .GATED (GATED)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sck_i  (synced[0]),
    .en_i   (synced[2]),
    .step_o (step)
  );

  serdisp_shift #(
    .PAYLOAD (PAYLOAD)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .step_i  (step),
    .dat_i   (synced[1]),
    .load_o  (load),
    .frame_o (frame)
  );

  serdisp_latch #(
    .PAYLOAD (PAYLOAD),
    .NOUT    (NOUT)
  ) u_latch (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ld_i    (load),
    .frame_i (frame),
    .seg_o   (seg_o)
  );

endmodule

// File: tb/tb_serdisp_latch_top.sv
module tb_serdisp_latch_top;

  localparam int P    = 35;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_a = 1'b0, sck_b = 1'b0, sdi = 1'b0, en = 1'b1;
  logic [34:0] seg_a;
  logic [33:0] seg_b;

  always #4 clk = ~clk;

  serdisp_latch_top #(.GATED(1'b0)) dut (
    .clk_i(clk), .rst_i(rst), .ser_clk_i(sck_a), .ser_dat_i(sdi),
    .ser_en_i(en), .seg_o(seg_a));

  serdisp_latch_top #(.GATED(1'b1)) dut_en (
    .clk_i(clk), .rst_i(rst), .ser_clk_i(sck_b), .ser_dat_i(sdi),
    .ser_en_i(en), .seg_o(seg_b));

  int total = 0;
  int bad   = 0;
  bit mon_on = 1'b0;
  bit ended  = 1'b0;

  logic [34:0] qa[$];
  string       qa_tag[$];
  logic [34:0] qb[$];
  string       qb_tag[$];
  logic [34:0] last_a = '0, last_b = '0;
  logic [34:0] prev_a = '0, prev_b = '0;

  // monitor: every output change must match the next queued expectation
  always @(negedge clk) begin : mon
    logic [34:0] e;
    string t;
    if (mon_on) begin
      if (seg_a !== prev_a) begin
        total++;
        if (qa.size() == 0) begin
          bad++;
          $display("FAIL R4 R5 dut unexpected change act=%h exp=%h", seg_a, prev_a);
        end else begin
          e = qa.pop_front(); t = qa_tag.pop_front();
          if (seg_a !== e) begin
            bad++;
            $display("FAIL %s dut act=%h exp=%h", t, seg_a, e);
          end
        end
      end
      if ({1'b0, seg_b} !== prev_b) begin
        total++;
        if (qb.size() == 0) begin
          bad++;
          $display("FAIL R4 R5 dut_en unexpected change act=%h exp=%h", seg_b, prev_b);
        end else begin
          e = qb.pop_front(); t = qb_tag.pop_front();
          if ({1'b0, seg_b} !== e) begin
            bad++;
            $display("FAIL %s dut_en act=%h exp=%h", t, seg_b, e);
          end
        end
      end
    end
    prev_a = seg_a;
    prev_b = {1'b0, seg_b};
  end

  task automatic expect_a(input logic [34:0] v, input string t);
    if (v !== last_a) begin qa.push_back(v); qa_tag.push_back(t); last_a = v; end
  endtask

  task automatic expect_b(input logic [34:0] p, input string t);
    logic [34:0] v;
    v = {1'b0, p[33:0]};
    if (v !== last_b) begin qb.push_back(v); qb_tag.push_back(t); last_b = v; end
  endtask

  task automatic check(input bit ok, input string t, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b, input bit ta, input bit tb);
    @(negedge clk);
    sdi = b; sck_a = 1'b0; sck_b = 1'b0;
    repeat (HALF) @(negedge clk);
    sck_a = ta; sck_b = tb;
    repeat (HALF) @(negedge clk);
    sck_a = 1'b0; sck_b = 1'b0;
  endtask

  task automatic send_frame(input logic [34:0] p, input bit ta, input bit tb, input string t);
    if (ta) expect_a(p, t);
    if (tb) expect_b(p, t);
    ser_bit(1'b1, ta, tb);
    for (int i = 0; i < P; i++) ser_bit(p[i], ta, tb);
  endtask

  task automatic drain(input string t);
    repeat (8) @(negedge clk);
    check(qa.size() == 0, {t, " dut load missing"}, seg_a, (qa.size() > 0) ? qa[0] : last_a);
    check(qb.size() == 0, {t, " dut_en load missing"}, {1'b0, seg_b}, (qb.size() > 0) ? qb[0] : last_b);
  endtask

  task automatic pulse_reset(input string t);
    expect_a('0, t); expect_b('0, t);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [34:0] p;
    rst = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(seg_a == '0, "R10 reset dut", seg_a, '0);
    check(seg_b == '0, "R10 reset dut_en", {1'b0, seg_b}, '0);
    mon_on = 1'b1;

    // R1 R2: basic transfer
    send_frame(35'h5_A5C3_1E97, 1, 1, "R1 R2 pattern A"); drain("R1");

    // R2: first payload bit -> seg_o[0]
    send_frame(35'h0_0000_0001, 1, 1, "R2 first bit"); drain("R2");
    check(seg_a[0] == 1'b1 && seg_b[0] == 1'b1, "R2 bit0", {34'b0, seg_a[0]}, 35'h1);

    // R2 R8: last payload bit -> seg_o[34], dropped in gated variant
    send_frame(35'h4_0000_0000, 1, 1, "R2 R8 last bit"); drain("R8");
    check(seg_a[34] == 1'b1, "R2 bit34", seg_a, 35'h4_0000_0000);
    check(seg_b == '0, "R8 35th dropped", {1'b0, seg_b}, '0);

    // R7: zeros before the marker are discarded
    for (int i = 0; i < 6; i++) ser_bit(1'b0, 1, 1);
    repeat (8) @(negedge clk);
    check(seg_a == last_a, "R7 zeros no load", seg_a, last_a);
    send_frame(35'h2_3C4B_5A69, 1, 1, "R7 after zeros"); drain("R7");

    // R4: outputs stable mid-transfer
    p = 35'h7_0F0F_0F0F;
    expect_a(p, "R4 partial"); expect_b(p, "R4 partial");
    ser_bit(1'b1, 1, 1);
    for (int i = 0; i < 20; i++) ser_bit(p[i], 1, 1);
    check(seg_a == 35'h2_3C4B_5A69, "R4 hold mid dut", seg_a, 35'h2_3C4B_5A69);
    check({1'b0, seg_b} == {1'b0, 34'h2_3C4B_5A69}, "R4 hold mid dut_en", {1'b0, seg_b}, {1'b0, 34'h2_3C4B_5A69});
    for (int i = 20; i < P; i++) ser_bit(p[i], 1, 1);
    drain("R4");

    // R5: same payload again -> no change (monitor flags any)
    send_frame(p, 1, 1, "R5 same"); drain("R5");
    check(seg_a == p, "R5 unchanged", seg_a, p);

    // R6: back-to-back transfers
    send_frame(35'h1_2345_6789, 1, 1, "R6 first");
    send_frame(35'h6_DCBA_9876, 1, 1, "R6 second"); drain("R6");

    // R8: enable low holds the partial transfer in dut_en
    p = 35'h3_5555_AAAA;
    expect_b(p, "R8 gated hold");
    ser_bit(1'b1, 0, 1);
    for (int i = 0; i < 15; i++) ser_bit(p[i], 0, 1);
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 5; i++) ser_bit(1'b1, 0, 1);
    @(negedge clk); en = 1'b1;
    for (int i = 15; i < P; i++) ser_bit(p[i], 0, 1);
    drain("R8");
    check(seg_a == 35'h6_DCBA_9876, "R8 dut untouched", seg_a, 35'h6_DCBA_9876);

    // R9: ungated variant ignores enable
    @(negedge clk); en = 1'b0;
    send_frame(35'h0_F00D_CAFE, 1, 0, "R9 enable ignored"); drain("R9");
    @(negedge clk); en = 1'b1;

    // R10: reset mid-transfer discards partial data
    ser_bit(1'b1, 1, 1);
    for (int i = 0; i < 17; i++) ser_bit(1'b1, 1, 1);
    pulse_reset("R10 mid reset");
    send_frame(35'h5_1234_4321, 1, 1, "R10 after reset"); drain("R10");

    // R10: reset in the same cycle as the load wins
    p = 35'h2_AAAA_5555;
    expect_a('0, "R10 reset on load"); expect_b('0, "R10 reset on load");
    ser_bit(1'b1, 1, 1);
    for (int i = 0; i < P - 1; i++) ser_bit(p[i], 1, 1);
    @(negedge clk);
    sdi = p[P-1]; sck_a = 1'b0; sck_b = 1'b0;
    repeat (HALF) @(negedge clk);
    sck_a = 1'b1; sck_b = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (HALF - 3) @(negedge clk);
    sck_a = 1'b0; sck_b = 1'b0;
    drain("R10 collide");
    check(seg_a == '0, "R10 collide zero", seg_a, '0);
    send_frame(35'h7_7777_1111, 1, 1, "R6 R10 after collide"); drain("R10 R6");

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule